// File: doc/BRIEF.md
# Accumulator Bank with Move-Encoded ALU

This block is the arithmetic heart of a move-based processor datapath. It keeps a bank of sixteen 16-bit accumulators, a pointer naming which one is active, a small pointer-step control register, a carry flag and an equal flag. It also derives a zero flag from the active accumulator. Every operation arrives as a decoded move: a source module and subdecode, a destination module and subdecode, a flag saying whether the source is a register or an immediate, and the already-resolved 16-bit source value. A single strobe qualifies each move, and one move completes per clock.

The function is selected entirely by the module and subdecode codes. Writing to the accumulator-function module (code 10) runs the source value through the ALU against the active accumulator. When code 10 is both source and destination, the move becomes a single-operand shift, rotate or exchange, or a carry-bit operation. Module 9 addresses the accumulators directly. Module 8 holds the pointer (subdecode 0), the step control (subdecode 1) and the compare port (subdecode 7). Reading the active accumulator through code 10, subdecode 0, steps the pointer with a wrap on a selectable power-of-two window. This makes multi-word arithmetic sweep through the bank without explicit pointer updates.

Top module: `acc_unit`

## Requirements
- R1: After synchronous reset every accumulator, the pointer, the step control, carry and equal are 0, and the zero flag reads 1.
- R2: A move to module 9 subdecode n loads accumulator n with the source value. With src_mod = 9 and src_sub = n, rd_data returns accumulator n; with src_mod = 10 it returns the active accumulator; with src_mod = 8 it returns the pointer (sub 0) or the step control (sub 1).
- R3: With destination module 10 and a source that is not register module 10, destination subdecodes 0 to 3 give MOVE, AND, OR and XOR of the source into the active accumulator, leaving carry unchanged.
- R4: Destination subdecodes 4 to 7 give ADD, SUB, ADDC and SUBB. ADD and ADDC set carry to the carry out of bit 15. SUB and SUBB set carry to the borrow. ADDC adds carry and SUBB subtracts it.
- R5: With module 10 as both source and destination and destination subdecode 0, source subdecode 0..15 selects, in order: no change, complement, shift-left-1, shift-left-2, rotate-left, rotate-left-through-carry, shift-left-4, nibble swap within each byte (0x1234 to 0x2143), byte swap (0x1234 to 0x3412), negate, logical shift-right-1, shift-right-4, rotate-right, rotate-right-through-carry, shift-right-2, shift-right-1. All right shifts fill with zeros.
- R6: The carry output of those operations is as follows: shift-left-1, rotate-left and rotate-left-through-carry take bit 15; shift-left-2 takes bit 14; shift-left-4 takes bit 12; shift-right-4 takes bit 3; shift-right-2 takes bit 1; the shift-right-1 forms and both right rotates take bit 0. No change, complement, the swaps and negate leave carry alone.
- R7: With module 10 as both source and destination and destination subdecode 5, source subdecode 0 clears carry, 1 sets it, 2 inverts it, and 3 changes nothing at all.
- R8: With module 10 as both source and destination, the source subdecode names accumulator bit b. Destination subdecodes 1, 2 and 3 replace carry with carry AND, OR or XOR bit b. Subdecode 6 copies bit b into carry. Subdecode 7 copies carry into bit b.
- R9: A move whose source is register module 10 subdecode 0, to any destination other than module 10, steps the pointer after the move. Subdecode 1 never steps it. Step control bit 2 set means decrement, and bits 1:0 = k give a wrap window of 2^(k+1) entries.
- R10: A step changes only the pointer bits inside the window; the bits above it are kept.
- R11: The zero flag is 1 exactly when the active accumulator is 0. A move to module 8 subdecode 7 sets equal when the source equals the active accumulator and clears it otherwise.
- R12: With op_valid low, no accumulator, flag, pointer or control changes.
- R13: When the same move both writes the pointer (module 8 subdecode 0) and would step it, the written value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Qualifies the move on the other inputs |
| src_is_reg | input | 1 | 1 = source is a register designator, 0 = immediate |
| src_mod | input | 4 | Source module code |
| src_sub | input | 4 | Source subdecode |
| dst_mod | input | 4 | Destination module code |
| dst_sub | input | 4 | Destination subdecode |
| src_data | input | 16 | Resolved source operand |
| rd_data | output | 16 | Read value selected by src_mod/src_sub |
| active_acc | output | 16 | Current active accumulator |
| acc_ptr | output | 4 | Active accumulator pointer |
| carry_flag | output | 1 | Carry |
| zero_flag | output | 1 | NOR of the active accumulator |
| equal_flag | output | 1 | Result of the last compare |

## Verification
The single-operand group is run over four accumulator patterns, each with carry at 0 and at 1. The patterns set the copied carry bits (15, 14, 12, 3, 1, 0) to differing values, so a wrong tap or a wrong fill bit shows up, and carry-in separates the through-carry rotates from the plain ones. Arithmetic is driven across the 0xFFFF/0x0000 boundary, which exposes carry and borrow polarity and a missing carry-in. Pointer steps start near a window edge with nonzero upper bits, in both directions and in several window sizes, which tells a masked wrap from a plain increment.

// File: rtl/acc_pkg.sv
package acc_pkg;

    // Module codes that the unit decodes
    localparam logic [3:0] MOD_SYS = 4'd8;   // pointer, step control, compare
    localparam logic [3:0] MOD_ARR = 4'd9;   // direct accumulator access
    localparam logic [3:0] MOD_AFN = 4'd10;  // accumulator functions

    // Subdecodes inside the system module
    localparam logic [3:0] SYS_PTR  = 4'd0;
    localparam logic [3:0] SYS_CTRL = 4'd1;
    localparam logic [3:0] SYS_CMP  = 4'd7;

    // Two-operand ALU selection (destination subdecode, source not AFN)
    typedef enum logic [2:0] {
        ALU_MOV, ALU_AND, ALU_OR, ALU_XOR,
        ALU_ADD, ALU_SUB, ALU_ADC, ALU_SBB
    } alu_op_e;

    // Single-operand selection (source subdecode, AFN to AFN, dst sub 0)
    typedef enum logic [3:0] {
        UN_NOP, UN_CPL, UN_SL1, UN_SL2, UN_ROL, UN_ROLC, UN_SL4, UN_NIB,
        UN_BYTE, UN_NEG, UN_SR1, UN_SR4, UN_ROR, UN_RORC, UN_SR2, UN_SRZ
    } un_op_e;

    // Destination subdecode groups when AFN is both source and destination
    localparam logic [3:0] BOP_UNARY = 4'd0;
    localparam logic [3:0] BOP_AND   = 4'd1;
    localparam logic [3:0] BOP_OR    = 4'd2;
    localparam logic [3:0] BOP_XOR   = 4'd3;
    localparam logic [3:0] BOP_CARRY = 4'd5;
    localparam logic [3:0] BOP_LDC   = 4'd6;
    localparam logic [3:0] BOP_STC   = 4'd7;

    // Pointer step control
    typedef struct packed {
        logic       dir_down;
        logic [1:0] mod_code;
    } step_ctrl_t;

endpackage

// File: rtl/acc_regfile.sv
module acc_regfile #(
    parameter int DATA_W  = 16,
    parameter int NUM_ACC = 16,
    parameter int PTR_W   = $clog2(NUM_ACC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [PTR_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [PTR_W-1:0]  ridx,
    output logic [DATA_W-1:0] rdata,
    input  logic [PTR_W-1:0]  aidx,
    output logic [DATA_W-1:0] adata
);
    logic [DATA_W-1:0] bank [NUM_ACC];

    for (genvar g = 0; g < NUM_ACC; g++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst)
                bank[g] <= '0;
            else if (we && widx == PTR_W'(g))
                bank[g] <= wdata;
        end
    end

    assign rdata = bank[ridx];
    assign adata = bank[aidx];
endmodule

// File: rtl/acc_ptr.sv
module acc_ptr
    import acc_pkg::*;
#(
    parameter int NUM_ACC = 16,
    parameter int PTR_W   = $clog2(NUM_ACC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ptr_we,
    input  logic [PTR_W-1:0] ptr_wdata,
    input  logic             ctrl_we,
    input  step_ctrl_t       ctrl_wdata,
    input  logic             step_en,
    output logic [PTR_W-1:0] ptr_q,
    output step_ctrl_t       ctrl_q
);
    logic [PTR_W-1:0] win_mask;
    logic [PTR_W-1:0] stepped;
    logic [PTR_W-1:0] ptr_next;

    assign win_mask = PTR_W'((32'd2 << ctrl_q.mod_code) - 32'd1);
    assign stepped  = ctrl_q.dir_down ? ptr_q - 1'b1 : ptr_q + 1'b1;
    assign ptr_next = (ptr_q & ~win_mask) | (stepped & win_mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q  <= '0;
            ctrl_q <= '0;
        end else begin
            if (ptr_we)
                ptr_q <= ptr_wdata;
            else if (step_en)
                ptr_q <= ptr_next;
            if (ctrl_we)
                ctrl_q <= ctrl_wdata;
        end
    end

    a_r10_upper_kept: assert property (@(posedge clk) disable iff (rst)
        (step_en && !ptr_we && !ctrl_we) |=>
            ((ptr_q & ~$past(win_mask)) == ($past(ptr_q) & ~$past(win_mask))));

    a_r9_no_step: assert property (@(posedge clk) disable iff (rst)
        (!ptr_we && !step_en) |=> $stable(ptr_q));

    a_r13_write_wins: assert property (@(posedge clk) disable iff (rst)
        ptr_we |=> (ptr_q == $past(ptr_wdata)));
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              src_is_afn,
    input  logic              dst_is_afn,
    input  logic [3:0]        src_sub,
    input  logic [3:0]        dst_sub,
    input  logic [DATA_W-1:0] operand,
    input  logic [DATA_W-1:0] acc_in,
    input  logic              c_in,
    output logic [DATA_W-1:0] acc_out,
    output logic              acc_we,
    output logic              c_out,
    output logic              c_we
);
    localparam int BIT_W  = $clog2(DATA_W);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0]   wide;
    logic [DATA_W-1:0] nib_swap;
    logic [BIT_W-1:0]  bsel;

    assign bsel = src_sub[BIT_W-1:0];

    always_comb begin
        for (int i = 0; i < DATA_W / 8; i++)
            nib_swap[i*8 +: 8] = {acc_in[i*8 +: 4], acc_in[i*8+4 +: 4]};
    end

    always_comb begin
        acc_out = acc_in;
        c_out   = c_in;
        acc_we  = 1'b0;
        c_we    = 1'b0;
        wide    = '0;
        if (dst_is_afn && !src_is_afn) begin
            if (!dst_sub[3]) begin
                acc_we = 1'b1;
                unique case (alu_op_e'(dst_sub[2:0]))
                    ALU_MOV: acc_out = operand;
                    ALU_AND: acc_out = acc_in & operand;
                    ALU_OR:  acc_out = acc_in | operand;
                    ALU_XOR: acc_out = acc_in ^ operand;
                    ALU_ADD: wide = {1'b0, acc_in} + {1'b0, operand};
                    ALU_SUB: wide = {1'b0, acc_in} - {1'b0, operand};
                    ALU_ADC: wide = {1'b0, acc_in} + {1'b0, operand} + {{DATA_W{1'b0}}, c_in};
                    ALU_SBB: wide = {1'b0, acc_in} - {1'b0, operand} - {{DATA_W{1'b0}}, c_in};
                    default: ;
                endcase
                if (dst_sub[2]) begin
                    acc_out = wide[DATA_W-1:0];
                    c_out   = wide[DATA_W];
                    c_we    = 1'b1;
                end
            end
        end else if (dst_is_afn && src_is_afn) begin
            unique case (dst_sub)
                BOP_UNARY: begin
                    acc_we = 1'b1;
                    unique case (un_op_e'(src_sub))
                        UN_NOP:  ;
                        UN_CPL:  acc_out = ~acc_in;
                        UN_SL1:  begin acc_out = acc_in << 1; c_out = acc_in[DATA_W-1]; c_we = 1'b1; end
                        UN_SL2:  begin acc_out = acc_in << 2; c_out = acc_in[DATA_W-2]; c_we = 1'b1; end
                        UN_ROL:  begin acc_out = {acc_in[DATA_W-2:0], acc_in[DATA_W-1]}; c_out = acc_in[DATA_W-1]; c_we = 1'b1; end
                        UN_ROLC: begin acc_out = {acc_in[DATA_W-2:0], c_in}; c_out = acc_in[DATA_W-1]; c_we = 1'b1; end
                        UN_SL4:  begin acc_out = acc_in << 4; c_out = acc_in[DATA_W-4]; c_we = 1'b1; end
                        UN_NIB:  acc_out = nib_swap;
                        UN_BYTE: acc_out = {acc_in[HALF_W-1:0], acc_in[DATA_W-1:HALF_W]};
                        UN_NEG:  acc_out = -acc_in;
                        UN_SR1:  begin acc_out = acc_in >> 1; c_out = acc_in[0]; c_we = 1'b1; end
                        UN_SR4:  begin acc_out = acc_in >> 4; c_out = acc_in[3]; c_we = 1'b1; end
                        UN_ROR:  begin acc_out = {acc_in[0], acc_in[DATA_W-1:1]}; c_out = acc_in[0]; c_we = 1'b1; end
                        UN_RORC: begin acc_out = {c_in, acc_in[DATA_W-1:1]}; c_out = acc_in[0]; c_we = 1'b1; end
                        UN_SR2:  begin acc_out = acc_in >> 2; c_out = acc_in[1]; c_we = 1'b1; end
                        UN_SRZ:  begin acc_out = acc_in >> 1; c_out = acc_in[0]; c_we = 1'b1; end
                        default: ;
                    endcase
                end
                BOP_AND: begin c_out = c_in & acc_in[bsel]; c_we = 1'b1; end
                BOP_OR:  begin c_out = c_in | acc_in[bsel]; c_we = 1'b1; end
                BOP_XOR: begin c_out = c_in ^ acc_in[bsel]; c_we = 1'b1; end
                BOP_LDC: begin c_out = acc_in[bsel];        c_we = 1'b1; end
                BOP_STC: begin acc_out[bsel] = c_in;        acc_we = 1'b1; end
                BOP_CARRY: begin
                    unique case (src_sub)
                        4'd0:    begin c_out = 1'b0;  c_we = 1'b1; end
                        4'd1:    begin c_out = 1'b1;  c_we = 1'b1; end
                        4'd2:    begin c_out = ~c_in; c_we = 1'b1; end
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/acc_unit.sv
module acc_unit
    import acc_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int NUM_ACC = 16,
    localparam int PTR_W  = $clog2(NUM_ACC)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic              src_is_reg,
    input  logic [3:0]        src_mod,
    input  logic [3:0]        src_sub,
    input  logic [3:0]        dst_mod,
    input  logic [3:0]        dst_sub,
    input  logic [DATA_W-1:0] src_data,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] active_acc,
    output logic [PTR_W-1:0]  acc_ptr,
    output logic              carry_flag,
    output logic              zero_flag,
    output logic              equal_flag
);
    localparam int CTRL_W = $bits(step_ctrl_t);

    logic              src_is_afn, dst_is_afn;
    logic              arr_we, ptr_we, ctrl_we, cmp_we, step_en;
    logic [DATA_W-1:0] alu_acc;
    logic              alu_acc_we, alu_c, alu_c_we;
    logic              rf_we;
    logic [PTR_W-1:0]  rf_widx;
    logic [DATA_W-1:0] rf_wdata, arr_rdata;
    step_ctrl_t        ctrl_q;

    assign src_is_afn = src_is_reg && (src_mod == MOD_AFN);
    assign dst_is_afn = (dst_mod == MOD_AFN);
    assign arr_we     = op_valid && (dst_mod == MOD_ARR);
    assign ptr_we     = op_valid && (dst_mod == MOD_SYS) && (dst_sub == SYS_PTR);
    assign ctrl_we    = op_valid && (dst_mod == MOD_SYS) && (dst_sub == SYS_CTRL);
    assign cmp_we     = op_valid && (dst_mod == MOD_SYS) && (dst_sub == SYS_CMP);
    assign step_en    = op_valid && src_is_afn && (src_sub == 4'd0) && !dst_is_afn;

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .src_is_afn (src_is_afn),
        .dst_is_afn (dst_is_afn),
        .src_sub    (src_sub),
        .dst_sub    (dst_sub),
        .operand    (src_data),
        .acc_in     (active_acc),
        .c_in       (carry_flag),
        .acc_out    (alu_acc),
        .acc_we     (alu_acc_we),
        .c_out      (alu_c),
        .c_we       (alu_c_we)
    );

    assign rf_we    = arr_we || (op_valid && alu_acc_we);
    assign rf_widx  = arr_we ? dst_sub[PTR_W-1:0] : acc_ptr;
    assign rf_wdata = arr_we ? src_data : alu_acc;

    acc_regfile #(.DATA_W(DATA_W), .NUM_ACC(NUM_ACC), .PTR_W(PTR_W)) u_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (rf_we),
        .widx  (rf_widx),
        .wdata (rf_wdata),
        .ridx  (src_sub[PTR_W-1:0]),
        .rdata (arr_rdata),
        .aidx  (acc_ptr),
        .adata (active_acc)
    );

    acc_ptr #(.NUM_ACC(NUM_ACC), .PTR_W(PTR_W)) u_ptr (
        .clk        (clk),
        .rst        (rst),
        .ptr_we     (ptr_we),
        .ptr_wdata  (src_data[PTR_W-1:0]),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (step_ctrl_t'(src_data[CTRL_W-1:0])),
        .step_en    (step_en),
        .ptr_q      (acc_ptr),
        .ctrl_q     (ctrl_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            carry_flag <= 1'b0;
            equal_flag <= 1'b0;
        end else begin
            if (op_valid && alu_c_we)
                carry_flag <= alu_c;
            if (cmp_we)
                equal_flag <= (src_data == active_acc);
        end
    end

    assign zero_flag = ~|active_acc;

    always_comb begin
        rd_data = '0;
        if (src_mod == MOD_AFN)
            rd_data = active_acc;
        else if (src_mod == MOD_ARR)
            rd_data = arr_rdata;
        else if (src_mod == MOD_SYS && src_sub == SYS_PTR)
            rd_data = DATA_W'(acc_ptr);
        else if (src_mod == MOD_SYS && src_sub == SYS_CTRL)
            rd_data = DATA_W'(ctrl_q);
    end

    a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> ($stable(acc_ptr) && $stable(carry_flag) &&
                       $stable(equal_flag) && $stable(active_acc)));

    a_r4_add_sum: assert property (@(posedge clk) disable iff (rst)
        (op_valid && dst_is_afn && !src_is_afn && dst_sub == 4'd4) |=>
            (active_acc == DATA_W'($past(active_acc) + $past(src_data))));

    a_r11_cmp_equal: assert property (@(posedge clk) disable iff (rst)
        cmp_we |=> (equal_flag == ($past(src_data) == $past(active_acc))));

    a_r7_guard_nop: assert property (@(posedge clk) disable iff (rst)
        (op_valid && dst_is_afn && src_is_afn && dst_sub == 4'd5 && src_sub == 4'd3) |=>
            ($stable(carry_flag) && $stable(active_acc) && $stable(acc_ptr)));
endmodule

// File: tb/acc_unit_tb.sv
module acc_unit_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid, src_is_reg;
    logic [3:0]  src_mod, src_sub, dst_mod, dst_sub;
    logic [15:0] src_data;
    logic [15:0] rd_data, active_acc;
    logic [3:0]  acc_ptr;
    logic        carry_flag, zero_flag, equal_flag;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    acc_unit u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .src_is_reg(src_is_reg),
        .src_mod(src_mod), .src_sub(src_sub), .dst_mod(dst_mod), .dst_sub(dst_sub),
        .src_data(src_data), .rd_data(rd_data), .active_acc(active_acc),
        .acc_ptr(acc_ptr), .carry_flag(carry_flag), .zero_flag(zero_flag),
        .equal_flag(equal_flag)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic reg_src, input int sm, input int ss,
                         input int dm, input int ds, input logic [15:0] d);
        @(negedge clk);
        src_is_reg = reg_src; src_mod = 4'(sm); src_sub = 4'(ss);
        dst_mod = 4'(dm); dst_sub = 4'(ds); src_data = d; op_valid = 1'b1;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    task automatic peek(input int sm, input int ss, output logic [15:0] v);
        src_mod = 4'(sm); src_sub = 4'(ss);
        #1;
        v = rd_data;
    endtask

    task automatic set_ptr(input int p);     do_op(1'b0, 0, 0, 8, 0, 16'(p)); endtask
    task automatic set_ctrl(input int c);    do_op(1'b0, 0, 0, 8, 1, 16'(c)); endtask
    task automatic load_active(input logic [15:0] v); do_op(1'b0, 0, 0, 10, 0, v); endtask
    task automatic set_carry(input logic c); do_op(1'b1, 10, c ? 1 : 0, 10, 5, 16'h0); endtask

    function automatic logic [16:0] ref_unary(input int op, input logic [15:0] a, input logic c);
        logic [15:0] r;
        logic rc;
        r = a; rc = c;
        case (op)
            1:  r = ~a;
            2:  begin r = a << 1; rc = a[15]; end
            3:  begin r = a << 2; rc = a[14]; end
            4:  begin r = {a[14:0], a[15]}; rc = a[15]; end
            5:  begin r = {a[14:0], c}; rc = a[15]; end
            6:  begin r = a << 4; rc = a[12]; end
            7:  r = {a[11:8], a[15:12], a[3:0], a[7:4]};
            8:  r = {a[7:0], a[15:8]};
            9:  r = 16'h0 - a;
            10: begin r = a >> 1; rc = a[0]; end
            11: begin r = a >> 4; rc = a[3]; end
            12: begin r = {a[0], a[15:1]}; rc = a[0]; end
            13: begin r = {c, a[15:1]}; rc = a[0]; end
            14: begin r = a >> 2; rc = a[1]; end
            15: begin r = a >> 1; rc = a[0]; end
            default: ;
        endcase
        return {rc, r};
    endfunction

    task automatic t_reset();
        logic [15:0] v;
        chk("R1 ptr", acc_ptr, 0);
        chk("R1 carry", carry_flag, 0);
        chk("R1 equal", equal_flag, 0);
        chk("R1 zero", zero_flag, 1);
        chk("R1 active", active_acc, 0);
        for (int i = 0; i < 16; i++) begin
            peek(9, i, v);
            chk("R1 acc", v, 0);
        end
        peek(8, 1, v);
        chk("R1 ctrl", v, 0);
    endtask

    task automatic t_load();
        logic [15:0] v;
        set_ptr(0);
        do_op(1'b0, 0, 0, 9, 3, 16'hBEEF);
        do_op(1'b0, 0, 0, 9, 15, 16'h1234);
        peek(9, 3, v);  chk("R2 acc3", v, 16'hBEEF);
        peek(9, 15, v); chk("R2 acc15", v, 16'h1234);
        peek(9, 0, v);  chk("R2 acc0 untouched", v, 0);
        set_ptr(3);
        peek(10, 0, v); chk("R2 active read", v, 16'hBEEF);
        peek(8, 0, v);  chk("R2 ptr read", v, 3);
        chk("R2 active port", active_acc, 16'hBEEF);
    endtask

    task automatic t_logic();
        set_ptr(0);
        set_carry(1'b1);
        load_active(16'hF0F0);            chk("R3 move", active_acc, 16'hF0F0);
        do_op(1'b0, 0, 0, 10, 1, 16'hFF00); chk("R3 and", active_acc, 16'hF000);
        do_op(1'b0, 0, 0, 10, 2, 16'h000F); chk("R3 or", active_acc, 16'hF00F);
        do_op(1'b0, 0, 0, 10, 3, 16'hFFFF); chk("R3 xor", active_acc, 16'h0FF0);
        chk("R3 carry kept", carry_flag, 1);
        do_op(1'b1, 9, 3, 10, 0, 16'h5555); chk("R3 reg source move", active_acc, 16'h5555);
    endtask

    task automatic t_arith();
        set_ptr(0);
        set_carry(1'b0);
        load_active(16'hFFFF);
        do_op(1'b0, 0, 0, 10, 4, 16'h0001);
        chk("R4 add wrap", active_acc, 0);
        chk("R4 add carry", carry_flag, 1);
        chk("R11 zero set", zero_flag, 1);
        do_op(1'b0, 0, 0, 10, 6, 16'h0005);
        chk("R4 addc", active_acc, 6);
        chk("R4 addc carry", carry_flag, 0);
        chk("R11 zero clear", zero_flag, 0);
        do_op(1'b0, 0, 0, 10, 5, 16'h0007);
        chk("R4 sub", active_acc, 16'hFFFF);
        chk("R4 sub borrow", carry_flag, 1);
        do_op(1'b0, 0, 0, 10, 7, 16'hFFFE);
        chk("R4 subb", active_acc, 0);
        chk("R4 subb borrow", carry_flag, 0);
        load_active(16'h0010);
        do_op(1'b0, 0, 0, 10, 5, 16'h0003);
        chk("R4 sub no borrow", carry_flag, 0);
        chk("R4 sub value", active_acc, 16'h000D);
    endtask

    task automatic t_unary();
        logic [15:0] pats [4];
        logic [16:0] e;
        pats[0] = 16'h1234; pats[1] = 16'h8001; pats[2] = 16'h4008; pats[3] = 16'h100A;
        set_ptr(0);
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 2; c++) begin
                for (int op = 0; op < 16; op++) begin
                    load_active(pats[p]);
                    set_carry(c[0]);
                    do_op(1'b1, 10, op, 10, 0, 16'h0);
                    e = ref_unary(op, pats[p], c[0]);
                    chk($sformatf("R5 unary op%0d pat%0d", op, p), active_acc, e[15:0]);
                    chk($sformatf("R6 carry op%0d pat%0d c%0d", op, p, c), carry_flag, e[16]);
                end
            end
        end
        load_active(16'h1234); do_op(1'b1, 10, 7, 10, 0, 0);
        chk("R5 nibble swap", active_acc, 16'h2143);
        load_active(16'h1234); do_op(1'b1, 10, 8, 10, 0, 0);
        chk("R5 byte swap", active_acc, 16'h3412);
    endtask

    task automatic t_carry_ops();
        set_ptr(0);
        load_active(16'hA5A5);
        set_carry(1'b1);
        do_op(1'b1, 10, 0, 10, 5, 0); chk("R7 clear", carry_flag, 0);
        do_op(1'b1, 10, 1, 10, 5, 0); chk("R7 set", carry_flag, 1);
        do_op(1'b1, 10, 2, 10, 5, 0); chk("R7 invert", carry_flag, 0);
        do_op(1'b1, 10, 2, 10, 5, 0); chk("R7 invert back", carry_flag, 1);
        do_op(1'b1, 10, 3, 10, 5, 0);
        chk("R7 nop carry", carry_flag, 1);
        chk("R7 nop acc", active_acc, 16'hA5A5);
        chk("R7 nop ptr", acc_ptr, 0);
    endtask

    task automatic t_bitops();
        set_ptr(0);
        load_active(16'h0010);
        set_carry(1'b1);
        do_op(1'b1, 10, 4, 10, 1, 0); chk("R8 and bit4", carry_flag, 1);
        do_op(1'b1, 10, 3, 10, 1, 0); chk("R8 and bit3", carry_flag, 0);
        do_op(1'b1, 10, 4, 10, 2, 0); chk("R8 or bit4", carry_flag, 1);
        do_op(1'b1, 10, 4, 10, 3, 0); chk("R8 xor bit4", carry_flag, 0);
        do_op(1'b1, 10, 4, 10, 6, 0); chk("R8 load bit4", carry_flag, 1);
        do_op(1'b1, 10, 0, 10, 6, 0); chk("R8 load bit0", carry_flag, 0);
        do_op(1'b1, 10, 4, 10, 7, 0); chk("R8 store 0 to bit4", active_acc, 16'h0000);
        set_carry(1'b1);
        do_op(1'b1, 10, 15, 10, 7, 0); chk("R8 store 1 to bit15", active_acc, 16'h8000);
    endtask

    task automatic t_pointer();
        set_ptr(0);
        for (int i = 0; i < 16; i++) do_op(1'b0, 0, 0, 9, i, 16'(16'h1100 + i));
        set_ctrl(16'h0001);   // increment, window 4
        set_ptr(6);
        do_op(1'b1, 10, 0, 0, 0, 0); chk("R9 step up", acc_ptr, 7);
        chk("R9 active follows", active_acc, 16'h1107);
        do_op(1'b1, 10, 0, 0, 0, 0); chk("R10 wrap in window 4", acc_ptr, 4);
        do_op(1'b1, 10, 1, 0, 0, 0); chk("R9 sub1 no step", acc_ptr, 4);
        do_op(1'b1, 10, 0, 10, 0, 0); chk("R9 afn dest no step", acc_ptr, 4);
        set_ctrl(16'h0004);   // decrement, window 2
        set_ptr(5);
        do_op(1'b1, 10, 0, 0, 0, 0); chk("R9 step down", acc_ptr, 4);
        do_op(1'b1, 10, 0, 0, 0, 0); chk("R10 wrap in window 2", acc_ptr, 5);
        set_ctrl(16'h0007);   // decrement, window 16
        set_ptr(0);
        do_op(1'b1, 10, 0, 0, 0, 0); chk("R10 wrap in window 16", acc_ptr, 15);
        set_ctrl(16'h0002);   // increment, window 8
        do_op(1'b1, 10, 0, 0, 0, 0); chk("R10 wrap in window 8", acc_ptr, 8);
        do_op(1'b1, 10, 0, 9, 1, 16'h7777);
        chk("R9 step with array write", acc_ptr, 9);
        do_op(1'b1, 10, 0, 8, 0, 16'h0002);
        chk("R13 write wins", acc_ptr, 2);
        set_ctrl(0);
    endtask

    task automatic t_compare();
        set_ptr(0);
        load_active(16'h1234);
        do_op(1'b0, 0, 0, 8, 7, 16'h1234); chk("R11 equal set", equal_flag, 1);
        do_op(1'b0, 0, 0, 8, 7, 16'h1235); chk("R11 equal clear", equal_flag, 0);
        chk("R11 zero low", zero_flag, 0);
        chk("R11 compare leaves acc", active_acc, 16'h1234);
    endtask

    task automatic t_idle();
        set_ptr(0);
        load_active(16'h0042);
        set_carry(1'b0);
        @(negedge clk);
        src_is_reg = 1'b0; dst_mod = 4'd10; dst_sub = 4'd4; src_data = 16'h0005; op_valid = 1'b0;
        @(negedge clk);
        chk("R12 idle acc", active_acc, 16'h0042);
        chk("R12 idle carry", carry_flag, 0);
        dst_mod = 4'd8; dst_sub = 4'd0; src_data = 16'h0003;
        @(negedge clk);
        chk("R12 idle ptr", acc_ptr, 0);
        dst_mod = 4'd9; dst_sub = 4'd0; src_data = 16'hDEAD;
        @(negedge clk);
        chk("R12 idle array", active_acc, 16'h0042);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b0; src_is_reg = 1'b0;
        src_mod = '0; src_sub = '0; dst_mod = '0; dst_sub = '0; src_data = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_load();
        t_logic();
        t_arith();
        t_unary();
        t_carry_ops();
        t_bitops();
        t_pointer();
        t_compare();
        t_idle();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule